// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the interrupt entry and return sequences of a small 8-bit CPU core. Requests are only looked at on an instruction-boundary strobe from the core. A rising edge on the non-maskable request line is latched and is always taken. Maskable requests are level inputs, one per source, and are taken only while the interrupt-enable flag is set. When several maskable sources are pending, the lowest index wins. A non-maskable request beats every maskable one.

When an interrupt is accepted, the sequencer pushes the program counter and the A/F pair through a byte-wide memory port. The pushed F carries the enable flag in bit 5. The sequencer then clears the flag and reads a two-byte handler address from the vector area. That read is the acknowledge to the chosen source. The new PC is handed back to the core exactly twenty cycles after acceptance.

A return strobe pops F, A and the PC in the reverse order. It hands them back to the core and restores the enable flag from the popped F. EI and DI strobes from the decoder set and clear the flag, and EI only takes effect one instruction late. Decode, the ALU and the interrupt sources themselves stay outside the block.

Top module: `irq_seq`

## Requirements
- R1: Acceptance happens only on a `boundary` cycle while `busy` is low and `reti_stb` is low. A latched non-maskable request is taken whatever `int_en` is. Maskable `irq_req[k]` is taken only when `int_en` is 1, with the lowest pending k chosen. A non-maskable request wins over all maskable ones.
- R2: Entry writes four bytes, each at the stack pointer minus one, and the pointer steps down by one per byte. The order is PC[15:8], PC[7:0], A, F. `sp_out` ends 4 below its start value (reset value `SP_INIT`).
- R3: The pushed F byte equals `cur_f` with bit 5 replaced by the value `int_en` had in the acceptance cycle.
- R4: `int_en` is 0 in the cycle after the last push byte, for both non-maskable and maskable entries.
- R5: The vector low byte is read from `VEC_BASE + 2k` for source k, or from `NMI_VEC` for the non-maskable request, and the high byte from the next address. The low-byte read cycle carries a one-cycle acknowledge: `nmi_ack`, or `irq_ack` one-hot at bit k. The source drops its request in answer.
- R6: `pc_we` rises with `pc_out` equal to the handler address in the 20th cycle after the acceptance edge; the cycle holding `boundary` is not counted.
- R7: `int_en` resets to 0. DI clears it at the next edge. After EI, `int_en` becomes 1 at the second `boundary` that follows, so an interrupt can first be taken at the boundary after that.
- R8: A return reads F, A, PC[7:0], PC[15:0] high byte, each at the stack pointer, which then steps up by one. In the fifth cycle, `pc_we` and `af_we` are high together, with the popped PC, A and F on the outputs. In the next cycle `int_en` equals popped F bit 5 and `sp_out` is back at its value before entry.
- R9: `busy` is high for the whole entry (20 cycles) or return (5 cycles). While it is high, `ei_stb`, `di_stb`, `reti_stb` and `boundary` have no effect.
- R10: The non-maskable line is edge-triggered: holding it high after its acknowledge causes no second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_req | input | NSRC | Maskable request levels |
| cur_pc | input | 16 | Program counter of the core |
| cur_a | input | 8 | A register of the core |
| cur_f | input | 8 | F register of the core |
| mem_rdata | input | 8 | Memory read data, same cycle |
| busy | output | 1 | Entry or return sequence in progress |
| int_en | output | 1 | Interrupt-enable flag (F bit 5) |
| nmi_ack | output | 1 | Acknowledge to the non-maskable source |
| irq_ack | output | NSRC | One-hot acknowledge to a maskable source |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | PC to load into the core |
| pc_we | output | 1 | Load strobe for `pc_out` |
| a_out | output | 8 | Restored A |
| f_out | output | 8 | Restored F |
| af_we | output | 1 | Load strobe for `a_out`/`f_out` |

## Verification
A wrong step counter shows at once in the memory port: a byte lands at the wrong stack address, or the vector read is shifted. The twenty-cycle figure for `pc_we` is off by the same amount. A slip in the enable flag does not show in the cycle it happens. It shows as a wrong bit 5 in the pushed F, as a maskable request taken one boundary early, or as a wrong `int_en` value one cycle after the return strobe's fifth cycle. A stack-pointer error carries forward and is caught when `sp_out` fails to come back to its start value after the return.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int ADDR_W  = 16;
  localparam int IFF_BIT = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ENTRY, SEQ_RET} seq_mode_e;

  // F byte as pushed: the live flag value overrides bit IFF_BIT
  function automatic logic [7:0] mark_flag(input logic [7:0] f, input logic en);
    logic [7:0] r;
    r = f;
    r[IFF_BIT] = en;
    return r;
  endfunction

  // Address of the low vector byte for a source
  function automatic addr_t vec_addr(input addr_t base, input addr_t nmi_base,
                                     input logic is_nmi, input logic [7:0] src);
    return is_nmi ? nmi_base : addr_t'(base + (addr_t'(src) << 1));
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 4,
  parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             flag_en,
  input  logic             nmi_clear,
  output logic             want,
  output logic             pick_nmi,
  output logic [SRC_W-1:0] pick_src
);
  logic nmi_q;
  logic nmi_pend;
  logic found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_req;
      if (nmi_req && !nmi_q) nmi_pend <= 1'b1;
      else if (nmi_clear)    nmi_pend <= 1'b0;
    end
  end

  // scan downward so the lowest pending index is the one kept
  always_comb begin
    found    = 1'b0;
    pick_src = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (irq_req[i]) begin
        found    = 1'b1;
        pick_src = SRC_W'(i);
      end
    end
  end

  assign pick_nmi = nmi_pend;
  assign want     = nmi_pend || (flag_en && found);
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ei,
  input  logic di,
  input  logic bnd,
  input  logic clr,
  input  logic load,
  input  logic load_val,
  output logic int_en
);
  logic [1:0] ei_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en  <= 1'b0;
      ei_wait <= 2'd0;
    end else if (load) begin
      int_en  <= load_val;
      ei_wait <= 2'd0;
    end else if (clr || di) begin
      int_en  <= 1'b0;
      ei_wait <= 2'd0;
    end else if (ei) begin
      ei_wait <= bnd ? 2'd1 : 2'd2;
    end else if (bnd && ei_wait != 2'd0) begin
      ei_wait <= ei_wait - 2'd1;
      if (ei_wait == 2'd1) int_en <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter addr_t SP_INIT      = 16'h00F0,
  parameter int    ENTRY_STATES = 20,
  parameter int    CNT_W        = $clog2(ENTRY_STATES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_entry,
  input  logic       start_ret,
  input  addr_t      snap_pc,
  input  logic [7:0] snap_a,
  input  logic [7:0] snap_f,
  input  addr_t      snap_vec,
  input  logic [7:0] mem_rdata,
  output logic       busy,
  output addr_t      mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  output logic       mem_re,
  output addr_t      sp,
  output logic       push_done,
  output logic       vec_rd,
  output logic       seq_done,
  output logic       pc_we,
  output logic       af_we,
  output addr_t      pc_out,
  output logic [7:0] a_out,
  output logic [7:0] f_out
);
  localparam logic [CNT_W-1:0] LAST_ENT = CNT_W'(ENTRY_STATES);
  localparam logic [CNT_W-1:0] LAST_RET = CNT_W'(5);

  seq_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  addr_t            pc_r, vaddr_r;
  logic [7:0]       a_r, f_r, vlo, vhi;
  logic             in_ent, in_ret;

  assign in_ent = (mode == SEQ_ENTRY);
  assign in_ret = (mode == SEQ_RET);
  assign busy   = (mode != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= SEQ_IDLE;
      cnt     <= '0;
      sp      <= SP_INIT;
      pc_r    <= '0;
      vaddr_r <= '0;
      a_r     <= '0;
      f_r     <= '0;
      vlo     <= '0;
      vhi     <= '0;
    end else if (start_entry) begin
      mode    <= SEQ_ENTRY;
      cnt     <= CNT_W'(1);
      pc_r    <= snap_pc;
      a_r     <= snap_a;
      f_r     <= snap_f;
      vaddr_r <= snap_vec;
    end else if (start_ret) begin
      mode <= SEQ_RET;
      cnt  <= CNT_W'(1);
    end else if (busy) begin
      if (seq_done) begin
        mode <= SEQ_IDLE;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      if (mem_we) sp <= sp - addr_t'(1);
      if (in_ent && cnt == CNT_W'(5)) vlo <= mem_rdata;
      if (in_ent && cnt == CNT_W'(6)) vhi <= mem_rdata;
      if (in_ret && mem_re) begin
        sp <= sp + addr_t'(1);
        if (cnt == CNT_W'(1)) f_r <= mem_rdata;
        if (cnt == CNT_W'(2)) a_r <= mem_rdata;
        if (cnt == CNT_W'(3)) pc_r[7:0] <= mem_rdata;
        if (cnt == CNT_W'(4)) pc_r[15:8] <= mem_rdata;
      end
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp;
    mem_wdata = 8'h00;
    if (in_ent) begin
      if (cnt >= CNT_W'(1) && cnt <= CNT_W'(4)) begin
        mem_we   = 1'b1;
        mem_addr = sp - addr_t'(1);
        case (cnt)
          CNT_W'(1): mem_wdata = pc_r[15:8];
          CNT_W'(2): mem_wdata = pc_r[7:0];
          CNT_W'(3): mem_wdata = a_r;
          default:   mem_wdata = f_r;
        endcase
      end else if (cnt == CNT_W'(5) || cnt == CNT_W'(6)) begin
        mem_re   = 1'b1;
        mem_addr = (cnt == CNT_W'(5)) ? vaddr_r : vaddr_r + addr_t'(1);
      end
    end else if (in_ret && cnt <= CNT_W'(4)) begin
      mem_re = 1'b1;
    end
  end

  assign push_done = in_ent && (cnt == CNT_W'(4));
  assign vec_rd    = in_ent && (cnt == CNT_W'(5));
  assign seq_done  = (in_ent && cnt == LAST_ENT) || (in_ret && cnt == LAST_RET);
  assign pc_we     = seq_done;
  assign af_we     = in_ret && (cnt == LAST_RET);
  assign pc_out    = in_ent ? {vhi, vlo} : pc_r;
  assign a_out     = a_r;
  assign f_out     = f_r;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int    NSRC         = 4,
  parameter int    ENTRY_STATES = 20,
  parameter addr_t SP_INIT      = 16'h00F0,
  parameter addr_t VEC_BASE     = 16'h0010,
  parameter addr_t NMI_VEC      = 16'h0008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              reti_stb,
  input  logic              nmi_req,
  input  logic [NSRC-1:0]   irq_req,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [7:0]        cur_a,
  input  logic [7:0]        cur_f,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              int_en,
  output logic              nmi_ack,
  output logic [NSRC-1:0]   irq_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] sp_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_we,
  output logic [7:0]        a_out,
  output logic [7:0]        f_out,
  output logic              af_we
);
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic             idle, accept, accept_nmi, ret_go, bnd_idle;
  logic             want, pick_nmi;
  logic [SRC_W-1:0] pick_src, src_r;
  logic             nmi_r;
  logic             push_done, vec_rd, seq_done;
  addr_t            vec_a;

  assign idle       = !busy;
  assign bnd_idle   = boundary && idle;
  assign ret_go     = reti_stb && idle;
  assign accept     = bnd_idle && !reti_stb && want;
  assign accept_nmi = accept && pick_nmi;
  assign vec_a      = vec_addr(VEC_BASE, NMI_VEC, pick_nmi, 8'(pick_src));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_r <= '0;
      nmi_r <= 1'b0;
    end else if (accept) begin
      src_r <= pick_src;
      nmi_r <= pick_nmi;
    end
  end

  assign nmi_ack = vec_rd && nmi_r;
  assign irq_ack = (vec_rd && !nmi_r) ? (NSRC'(1) << src_r) : '0;

  irq_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_req   (nmi_req),
    .irq_req   (irq_req),
    .flag_en   (int_en),
    .nmi_clear (nmi_ack),
    .want      (want),
    .pick_nmi  (pick_nmi),
    .pick_src  (pick_src)
  );

  irq_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .ei       (ei_stb && idle),
    .di       (di_stb && idle),
    .bnd      (bnd_idle),
    .clr      (push_done),
    .load     (af_we),
    .load_val (f_out[IFF_BIT]),
    .int_en   (int_en)
  );

  irq_stack_seq #(.SP_INIT(SP_INIT), .ENTRY_STATES(ENTRY_STATES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_entry (accept),
    .start_ret   (ret_go),
    .snap_pc     (cur_pc),
    .snap_a      (cur_a),
    .snap_f      (mark_flag(cur_f, int_en)),
    .snap_vec    (vec_a),
    .mem_rdata   (mem_rdata),
    .busy        (busy),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .sp          (sp_out),
    .push_done   (push_done),
    .vec_rd      (vec_rd),
    .seq_done    (seq_done),
    .pc_we       (pc_we),
    .af_we       (af_we),
    .pc_out      (pc_out),
    .a_out       (a_out),
    .f_out       (f_out)
  );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NSRC         = 4,
  parameter int ENTRY_STATES = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            accept_nmi,
  input logic            int_en,
  input logic            busy,
  input logic            push_done,
  input logic            seq_done,
  input logic            mem_we,
  input logic            mem_re,
  input logic [15:0]     sp_out,
  input logic            nmi_ack,
  input logic [NSRC-1:0] irq_ack,
  input logic            pc_we,
  input logic            af_we,
  input logic            ret_flag,
  input logic            di_stb
);
  int unsigned ent_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ent_cnt <= 0;
    else if (accept)                     ent_cnt <= 1;
    else if (pc_we)                      ent_cnt <= 0;
    else if (ent_cnt != 0)               ent_cnt <= ent_cnt + 1;
  end

  a_r1_mask_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !accept_nmi) |-> int_en);

  a_r2_push_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) - 16'd1));

  a_r4_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> !int_en);

  a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_ack, irq_ack}));

  a_r5_ack_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack || (irq_ack != '0)) |-> mem_re);

  a_r6_twenty_states: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !af_we) |-> (ent_cnt == ENTRY_STATES));

  a_r7_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (di_stb && !busy) |=> !int_en);

  a_r8_flag_restored: assert property (@(posedge clk) disable iff (!rst_n)
    af_we |=> (int_en == $past(ret_flag)));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);
endmodule

bind irq_seq irq_seq_chk #(.NSRC(NSRC), .ENTRY_STATES(ENTRY_STATES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .accept_nmi (accept_nmi),
  .int_en     (int_en),
  .busy       (busy),
  .push_done  (push_done),
  .seq_done   (seq_done),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .sp_out     (sp_out),
  .nmi_ack    (nmi_ack),
  .irq_ack    (irq_ack),
  .pc_we      (pc_we),
  .af_we      (af_we),
  .ret_flag   (f_out[irq_seq_pkg::IFF_BIT]),
  .di_stb     (di_stb)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          NSRC       = 4;
  localparam logic [15:0] SP0        = 16'h00F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary = 1'b0, ei_stb = 1'b0, di_stb = 1'b0, reti_stb = 1'b0;
  logic        nmi_req = 1'b0;
  logic [3:0]  irq_req = '0;
  logic [15:0] cur_pc = '0;
  logic [7:0]  cur_a = '0, cur_f = '0;
  logic [7:0]  mem_rdata;
  logic        busy, int_en, nmi_ack, mem_we, mem_re, pc_we, af_we;
  logic [3:0]  irq_ack;
  logic [15:0] mem_addr, sp_out, pc_out;
  logic [7:0]  mem_wdata, a_out, f_out;

  logic [7:0] mem [256];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_seq u_dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .ei_stb(ei_stb), .di_stb(di_stb),
    .reti_stb(reti_stb), .nmi_req(nmi_req), .irq_req(irq_req), .cur_pc(cur_pc),
    .cur_a(cur_a), .cur_f(cur_f), .mem_rdata(mem_rdata), .busy(busy), .int_en(int_en),
    .nmi_ack(nmi_ack), .irq_ack(irq_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .sp_out(sp_out), .pc_out(pc_out), .pc_we(pc_we),
    .a_out(a_out), .f_out(f_out), .af_we(af_we)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_bnd();
    boundary = 1'b1;
    tick();
    boundary = 1'b0;
  endtask

  task automatic do_ei();
    ei_stb = 1'b1;
    tick();
    ei_stb = 1'b0;
    pulse_bnd();
    pulse_bnd();
  endtask

  task automatic do_di();
    di_stb = 1'b1;
    tick();
    di_stb = 1'b0;
  endtask

  function automatic logic [15:0] handler(input bit is_nmi, input int src);
    return is_nmi ? 16'h0066 : {8'h40 + 8'(src), 8'h20 + 8'(src)};
  endfunction

  // called in the first cycle after the accepting boundary edge
  task automatic run_entry(input bit exp_nmi, input int exp_src, input bit prior_en, input bit poke);
    int n = 0;
    bit got = 0;
    logic [7:0] exp_f;
    logic [15:0] va;
    va = exp_nmi ? 16'h0008 : 16'(16 + 2 * exp_src);
    chk(busy == 1'b1, "R1 entry started", 32'(busy), 1);
    for (int k = 0; k < 40; k++) begin
      if (busy) n++;
      if (poke && n == 3) begin ei_stb = 1'b1; reti_stb = 1'b1; end
      else begin ei_stb = 1'b0; reti_stb = 1'b0; end
      if (nmi_ack || irq_ack != 4'b0) begin
        got = 1;
        chk(mem_addr == va && mem_re, "R5 ack on low vector read", 32'(mem_addr), 32'(va));
        if (exp_nmi) chk(nmi_ack && irq_ack == 4'b0, "R5 nmi ack", {27'd0, nmi_ack, irq_ack}, 32'h10);
        else chk(!nmi_ack && irq_ack == 4'(1 << exp_src), "R5 irq ack", {27'd0, nmi_ack, irq_ack}, 32'(1 << exp_src));
        irq_req = irq_req & ~irq_ack;
      end
      if (pc_we) break;
      tick();
    end
    ei_stb = 1'b0; reti_stb = 1'b0;
    chk(n == 20 && pc_we, "R6 handler jump after 20 states", 32'(n), 20);
    chk(pc_out == handler(exp_nmi, exp_src), "R6 handler address", 32'(pc_out), 32'(handler(exp_nmi, exp_src)));
    chk(got, "R5 ack seen", 32'(got), 1);
    tick();
    chk(!busy, "R9 busy ends", 32'(busy), 0);
    chk(!int_en, "R4 flag cleared on entry", 32'(int_en), 0);
    chk(sp_out == SP0 - 16'd4, "R2 sp after push", 32'(sp_out), 32'(SP0 - 16'd4));
    chk(mem[8'hEF] == cur_pc[15:8], "R2 pc high pushed", 32'(mem[8'hEF]), 32'(cur_pc[15:8]));
    chk(mem[8'hEE] == cur_pc[7:0], "R2 pc low pushed", 32'(mem[8'hEE]), 32'(cur_pc[7:0]));
    chk(mem[8'hED] == cur_a, "R2 A pushed", 32'(mem[8'hED]), 32'(cur_a));
    exp_f = (cur_f & 8'hDF) | (prior_en ? 8'h20 : 8'h00);
    chk(mem[8'hEC] == exp_f, "R3 pushed F carries flag", 32'(mem[8'hEC]), 32'(exp_f));
  endtask

  task automatic run_ret(input logic [15:0] pc, input logic [7:0] a, input logic [7:0] f);
    int n = 0;
    reti_stb = 1'b1;
    tick();
    reti_stb = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (busy) n++;
      if (pc_we) break;
      tick();
    end
    chk(n == 5 && af_we, "R8 return length", 32'(n), 5);
    chk(pc_out == pc, "R8 pc popped", 32'(pc_out), 32'(pc));
    chk(a_out == a && f_out == f, "R8 AF popped", {16'd0, a_out, f_out}, {16'd0, a, f});
    tick();
    chk(int_en == f[5], "R8 flag restored", 32'(int_en), 32'(f[5]));
    chk(sp_out == SP0 && !busy, "R8 sp restored", 32'(sp_out), 32'(SP0));
  endtask

  // {en, nmi, req[3:0], take, exp_nmi, exp_src[1:0]}
  localparam logic [9:0] VECS [7] = '{
    {1'b1, 1'b0, 4'b0001, 1'b1, 1'b0, 2'd0},
    {1'b1, 1'b0, 4'b1010, 1'b1, 1'b0, 2'd1},
    {1'b1, 1'b0, 4'b1000, 1'b1, 1'b0, 2'd3},
    {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 2'd0},
    {1'b1, 1'b1, 4'b0110, 1'b1, 1'b1, 2'd0},
    {1'b0, 1'b0, 4'b0100, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b1, 4'b0011, 1'b1, 1'b1, 2'd0}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int k = 0; k < NSRC; k++) begin
      mem[16 + 2 * k] = 8'h20 + 8'(k);
      mem[17 + 2 * k] = 8'h40 + 8'(k);
    end
    mem[8] = 8'h66;
    mem[9] = 8'h00;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    chk(!busy && !mem_we && !mem_re, "R9 idle after reset", {29'd0, busy, mem_we, mem_re}, 0);
    chk(!int_en, "R7 flag reset", 32'(int_en), 0);
    chk(sp_out == SP0, "R2 sp reset", 32'(sp_out), 32'(SP0));

    // table walk
    for (int i = 0; i < 7; i++) begin
      logic [9:0] v;
      logic [7:0] pf;
      v = VECS[i];
      cur_pc = 16'h1230 + 16'(i);
      cur_a  = 8'hA0 + 8'(i);
      cur_f  = i[0] ? 8'hFF : 8'h00;
      if (v[9]) do_ei(); else do_di();
      chk(int_en == v[9], "R7 flag set up", 32'(int_en), 32'(v[9]));
      if (v[8]) begin nmi_req = 1'b1; tick(); end
      irq_req = v[7:4];
      pulse_bnd();
      if (v[3]) begin
        run_entry(v[2], int'(v[1:0]), v[9], 1'b0);
        nmi_req = 1'b0;
        irq_req = '0;
        pf = (cur_f & 8'hDF) | (v[9] ? 8'h20 : 8'h00);
        run_ret(cur_pc, cur_a, pf);
      end else begin
        chk(!busy && !int_en, "R1 masked request not taken", {30'd0, busy, int_en}, 0);
        irq_req = '0;
      end
    end

    // R7: EI delay, pending request waits for the flag
    do_di();
    ei_stb = 1'b1; tick(); ei_stb = 1'b0;
    irq_req = 4'b0001;
    pulse_bnd();
    chk(!busy && !int_en, "R7 flag still off after first boundary", {30'd0, busy, int_en}, 0);
    pulse_bnd();
    chk(!busy && int_en, "R7 flag on after second boundary", {30'd0, busy, int_en}, 1);
    cur_pc = 16'h5555; cur_a = 8'h11; cur_f = 8'h00;
    pulse_bnd();
    run_entry(1'b0, 0, 1'b1, 1'b0);
    irq_req = '0;
    run_ret(16'h5555, 8'h11, 8'h20);

    // R7: DI clears
    do_di();
    chk(!int_en, "R7 DI clears flag", 32'(int_en), 0);

    // R9: strobes ignored while busy, R10 held NMI
    cur_pc = 16'h0ABC; cur_a = 8'h77; cur_f = 8'h5A;
    nmi_req = 1'b1; tick();
    pulse_bnd();
    run_entry(1'b1, 0, 1'b0, 1'b1);
    chk(sp_out == SP0 - 16'd4 && !busy, "R9 RETI ignored while busy", 32'(sp_out), 32'(SP0 - 16'd4));
    pulse_bnd();
    pulse_bnd();
    chk(!int_en, "R9 EI ignored while busy", 32'(int_en), 0);
    run_ret(16'h0ABC, 8'h77, 8'h5A & 8'hDF);
    pulse_bnd();
    chk(!busy, "R10 held NMI not retaken", 32'(busy), 0);
    nmi_req = 1'b0;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule